// File: doc/BRIEF.md
# Blanking and Amplifier Control

This block gathers every reason a video channel must be blanked or an external video power amplifier must be told to stand by. It produces one registered command set per system clock. The hardware sources are the flyback-derived blanking pulse (already polarity-corrected) and the on-screen-display fast-blank strobe. The software source is a permanent-blank register bit, which acts only when a test-enable bit is also set.

The block also decides whether the device is in standby. A preamplifier-standby register bit puts it there. So does a supply-low comparator flag, once that flag has been synchronised and has held a new value for several consecutive clock samples. In standby, video processing is flagged to stop, while the register interface is untouched.

A three-level amplifier-control code is derived with a fixed priority: standby, then blanking, then normal. The code is registered so that the pin driver sees a clean, glitch-free value.

Top module: `blank_amp_ctrl`

## Requirements
- R1: `video_black_o` is 1 one clock after either `blank_pulse_i` or `osd_fast_blank_i` is 1, and 0 one clock after both are 0.
- R2: `infra_black_o` is 1 one clock after `sw_blank_i` and `test_en_i` are both 1; with only one of them set it stays 0.
- R3: The supply-low flag is passed through a 2-stage synchroniser and must then show the same new value on 4 consecutive samples. A change of `supply_low_i` therefore reaches `proc_standby_o` exactly 7 clocks later, both on entry and on exit.
- R4: A supply-low pulse lasting fewer than 4 clocks has no effect on `proc_standby_o` or `amp_level_o`.
- R5: One clock after `pre_standby_i` is 1, `proc_standby_o` is 1 and `amp_level_o` is 2'b00 (standby).
- R6: One clock after `amp_standby_i` is 1, `amp_level_o` is 2'b00. In that state `amp_blank_en_i` and `blank_pulse_i` are ignored, and `proc_standby_o` is not raised by `amp_standby_i`.
- R7: Outside standby, with `amp_blank_en_i` = 1, `amp_level_o` is 2'b01 (blanking) one clock after `blank_pulse_i` is 1.
- R8: In all other cases `amp_level_o` is 2'b10 (normal). The code 2'b11 never appears.
- R9: While `rst_n` is low, `video_black_o` = 0, `infra_black_o` = 0, `proc_standby_o` = 1 and `amp_level_o` = 2'b00. The debounced supply-low state starts at "not low".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_pulse_i | input | 1 | Polarity-corrected line blanking pulse, high = blank |
| osd_fast_blank_i | input | 1 | On-screen-display fast-blank strobe, high = insert |
| supply_low_i | input | 1 | Asynchronous output-supply-low comparator flag |
| sw_blank_i | input | 1 | Software permanent-blank register bit |
| test_en_i | input | 1 | Test-enable bit that qualifies software blanking |
| amp_standby_i | input | 1 | Amplifier-standby register bit |
| pre_standby_i | input | 1 | Preamplifier and amplifier standby register bit |
| amp_blank_en_i | input | 1 | Amplifier blanking-level enable register bit |
| video_black_o | output | 1 | Force video to black level |
| infra_black_o | output | 1 | Force outputs to infra-black level |
| proc_standby_o | output | 1 | Video processing halted (device standby) |
| amp_level_o | output | 2 | Amplifier control: 00 standby, 01 blanking, 10 normal |

## Verification
Every direct-input result (R1, R2, R5–R8) is due one clock after the input changes. Each scenario task therefore drives its inputs on a falling edge, lets one rising edge pass and samples on the next falling edge.

The supply-low path is due seven clocks after the input changes. The bench checks it at six clocks, where the old value must remain, and again at seven clocks, where the new value must appear. This is done for both entry and exit. A three-clock pulse is held and then watched well past the seven-clock point, to show that it never reaches the outputs.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [1:0] {
        AMP_STBY  = 2'b00,
        AMP_BLANK = 2'b01,
        AMP_RUN   = 2'b10
    } amp_lvl_e;

    typedef struct packed {
        logic     video_black;
        logic     infra_black;
        logic     proc_standby;
        amp_lvl_e level;
    } bac_out_t;

endpackage

// File: rtl/bac_supply_filter.sv
module bac_supply_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(DEB_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   filt;
    } flt_t;

    flt_t st_d, st_q;
    logic sample;

    assign sample = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_i};
        if (sample != st_q.filt) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.filt = sample;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;

    // R3: the filtered state only moves after a full run of differing samples
    assert_flip_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (st_q.filt != $past(st_q.filt))) |-> ($past(st_q.cnt) == CNT_MAX));

    // R4: a sample that agrees with the filtered state clears the run counter
    assert_run_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(sample) == $past(st_q.filt))) |-> (st_q.cnt == '0));

endmodule

// File: rtl/bac_amp_level.sv
module bac_amp_level
    import bac_pkg::*;
(
    input  logic     standby_i,
    input  logic     blank_i,
    input  logic     blank_en_i,
    output amp_lvl_e level_o
);
    always_comb begin
        if (standby_i)                  level_o = AMP_STBY;
        else if (blank_en_i && blank_i) level_o = AMP_BLANK;
        else                            level_o = AMP_RUN;
    end
endmodule

// File: rtl/blank_amp_ctrl.sv
module blank_amp_ctrl
    import bac_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_pulse_i,
    input  logic       osd_fast_blank_i,
    input  logic       supply_low_i,
    input  logic       sw_blank_i,
    input  logic       test_en_i,
    input  logic       amp_standby_i,
    input  logic       pre_standby_i,
    input  logic       amp_blank_en_i,
    output logic       video_black_o,
    output logic       infra_black_o,
    output logic       proc_standby_o,
    output logic [1:0] amp_level_o
);
    localparam bac_out_t RST_VAL = '{video_black: 1'b0, infra_black: 1'b0,
                                     proc_standby: 1'b1, level: AMP_STBY};

    logic     supply_low_filt;
    logic     dev_standby;
    amp_lvl_e level_sel;
    bac_out_t out_d, out_q;

    bac_supply_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_LEN     (DEB_LEN)
    ) i_supply_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (supply_low_i),
        .filt_o (supply_low_filt)
    );

    assign dev_standby = supply_low_filt | pre_standby_i;

    bac_amp_level i_amp_level (
        .standby_i  (dev_standby | amp_standby_i),
        .blank_i    (blank_pulse_i),
        .blank_en_i (amp_blank_en_i),
        .level_o    (level_sel)
    );

    always_comb begin
        out_d              = out_q;
        out_d.video_black  = blank_pulse_i | osd_fast_blank_i;
        out_d.infra_black  = sw_blank_i & test_en_i;
        out_d.proc_standby = dev_standby;
        out_d.level        = level_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= RST_VAL;
        else        out_q <= out_d;
    end

    assign video_black_o  = out_q.video_black;
    assign infra_black_o  = out_q.infra_black;
    assign proc_standby_o = out_q.proc_standby;
    assign amp_level_o    = out_q.level;

    assert_video_black_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (video_black_o == ($past(blank_pulse_i) | $past(osd_fast_blank_i))));

    assert_infra_black_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(sw_blank_i) && $past(test_en_i))) |-> !infra_black_o);

    assert_pre_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pre_standby_i)) |-> (proc_standby_o && amp_level_o == 2'b00));

    assert_amp_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(amp_standby_i)) |-> (amp_level_o == 2'b00));

    assert_blank_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(proc_standby_o) && !$past(amp_standby_i) && !$past(pre_standby_i)
         && $past(amp_blank_en_i) && $past(blank_pulse_i) && !proc_standby_o) |-> (amp_level_o == 2'b01));

    assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        amp_level_o != 2'b11);

endmodule

// File: tb/test_blank_amp_ctrl.sv
module test_blank_amp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blank_pulse_i = 1'b0, osd_fast_blank_i = 1'b0, supply_low_i = 1'b0;
    logic       sw_blank_i = 1'b0, test_en_i = 1'b0, amp_standby_i = 1'b0;
    logic       pre_standby_i = 1'b0, amp_blank_en_i = 1'b0;
    logic       video_black_o, infra_black_o, proc_standby_o;
    logic [1:0] amp_level_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    blank_amp_ctrl i_blank_amp_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .blank_pulse_i    (blank_pulse_i),
        .osd_fast_blank_i (osd_fast_blank_i),
        .supply_low_i     (supply_low_i),
        .sw_blank_i       (sw_blank_i),
        .test_en_i        (test_en_i),
        .amp_standby_i    (amp_standby_i),
        .pre_standby_i    (pre_standby_i),
        .amp_blank_en_i   (amp_blank_en_i),
        .video_black_o    (video_black_o),
        .infra_black_o    (infra_black_o),
        .proc_standby_o   (proc_standby_o),
        .amp_level_o      (amp_level_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // let n rising edges pass, then stand on the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_r9();
        @(negedge clk);
        check("R9 video_black", video_black_o, 0);
        check("R9 infra_black", infra_black_o, 0);
        check("R9 proc_standby", proc_standby_o, 1);
        check("R9 level", amp_level_o, 0);
        rst_n = 1'b1;
        tick(1);
        check("R9/R8 level after reset", amp_level_o, 2);
        check("R9 proc_standby after reset", proc_standby_o, 0);
    endtask

    task automatic t_video_blank_r1();
        blank_pulse_i = 1'b1; tick(1);
        check("R1 blank pulse", video_black_o, 1);
        blank_pulse_i = 1'b0; osd_fast_blank_i = 1'b1; tick(1);
        check("R1 osd fast blank", video_black_o, 1);
        osd_fast_blank_i = 1'b0; tick(1);
        check("R1 none", video_black_o, 0);
    endtask

    task automatic t_sw_blank_r2();
        sw_blank_i = 1'b1; tick(1);
        check("R2 sw only", infra_black_o, 0);
        sw_blank_i = 1'b0; test_en_i = 1'b1; tick(1);
        check("R2 test only", infra_black_o, 0);
        sw_blank_i = 1'b1; tick(1);
        check("R2 both", infra_black_o, 1);
        sw_blank_i = 1'b0; test_en_i = 1'b0; tick(1);
        check("R2 cleared", infra_black_o, 0);
    endtask

    task automatic t_amp_blank_r7();
        amp_blank_en_i = 1'b1; blank_pulse_i = 1'b1; tick(1);
        check("R7 blanking level", amp_level_o, 1);
        blank_pulse_i = 1'b0; tick(1);
        check("R8 normal, pulse low", amp_level_o, 2);
        amp_blank_en_i = 1'b0; blank_pulse_i = 1'b1; tick(1);
        check("R8 normal, enable off", amp_level_o, 2);
        blank_pulse_i = 1'b0; tick(1);
    endtask

    task automatic t_pre_standby_r5();
        pre_standby_i = 1'b1; amp_blank_en_i = 1'b1; blank_pulse_i = 1'b1; tick(1);
        check("R5 proc_standby", proc_standby_o, 1);
        check("R5 level", amp_level_o, 0);
        pre_standby_i = 1'b0; tick(1);
        check("R5 released", proc_standby_o, 0);
        check("R7 after release", amp_level_o, 1);
        amp_blank_en_i = 1'b0; blank_pulse_i = 1'b0; tick(1);
    endtask

    task automatic t_amp_standby_r6();
        amp_standby_i = 1'b1; amp_blank_en_i = 1'b1; blank_pulse_i = 1'b1; tick(1);
        check("R6 level", amp_level_o, 0);
        check("R6 no device standby", proc_standby_o, 0);
        blank_pulse_i = 1'b0; tick(1);
        check("R6 blank ignored", amp_level_o, 0);
        amp_standby_i = 1'b0; amp_blank_en_i = 1'b0; tick(1);
        check("R8 back to normal", amp_level_o, 2);
    endtask

    task automatic t_supply_low_r3();
        supply_low_i = 1'b1;
        tick(6);
        check("R3 entry not yet at 6", proc_standby_o, 0);
        tick(1);
        check("R3 entry at 7", proc_standby_o, 1);
        check("R3 level standby", amp_level_o, 0);
        supply_low_i = 1'b0;
        tick(6);
        check("R3 exit not yet at 6", proc_standby_o, 1);
        tick(1);
        check("R3 exit at 7", proc_standby_o, 0);
        check("R3 level normal", amp_level_o, 2);
    endtask

    task automatic t_supply_glitch_r4();
        bit seen = 1'b0;
        supply_low_i = 1'b1; tick(3);
        supply_low_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (proc_standby_o || amp_level_o != 2'b10) seen = 1'b1;
            tick(1);
        end
        check("R4 short pulse ignored", seen, 0);
        check("R4 level after glitch", amp_level_o, 2);
    endtask

    initial begin
        t_reset_r9();
        t_video_blank_r1();
        t_sw_blank_r2();
        t_amp_blank_r7();
        t_pre_standby_r5();
        t_amp_standby_r6();
        t_supply_low_r3();
        t_supply_glitch_r4();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule